// File: doc/BRIEF.md
# Mask compress index generator

This block turns a sparse element mask into a dense list of element positions. On an accepted start it captures a mask of up to 64 bits and the current vector length. It then examines one mask bit per clock, from element 0 upward. For each set bit below the length, it emits a write of that element's position into the next free slot of an index vector.

When the scan ends, the block raises a one-cycle done pulse. Its count output then holds the number of selected elements. A following gather reads the selected elements through the index vector, and a scatter writes the results back to the same positions. The count serves as the new vector length for that sequence.

The block has no storage for the index vector itself. The consumer captures `idx_wr_en`, `idx_slot` and `idx_value`, and any slot that is never written keeps its old contents.

Top module: `mask_compress`

## Requirements
- R1: Selected positions are written in ascending order of element number. The first write goes to slot 0, and each further write goes to the slot one above the previous one.
- R2: Only mask bits whose element number is below the captured vector length take part. A length above 64 is treated as 64.
- R3: After done, `sel_count` equals the number of set mask bits below the length. It keeps that value until the next accepted start, which clears it to 0.
- R4: The scan takes one element per clock. The write decision for element k appears on the outputs k+1 clocks after the edge that accepts start.
- R5: `done` is high for exactly one clock. It rises max(L,1) clocks after the accepting edge, where L is the clamped length. When element L-1 is selected, its write appears in the same cycle as `done`.
- R6: A mask with no set bit below the length, including a length of 0, produces no write, a count of 0, and still produces the done pulse.
- R7: A start that arrives during a scan is ignored. The scan in progress keeps its mask, its length and its results.
- R8: After reset, `idx_wr_en` and `done` are low and `sel_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a scan; accepted only when idle |
| mask | input | 64 | Element predicate mask, bit k for element k |
| vec_len | input | 7 | Current vector length; values above 64 clamp to 64 |
| idx_wr_en | output | 1 | An index write is presented this cycle |
| idx_slot | output | 6 | Destination slot of the index write |
| idx_value | output | 6 | Element position being written |
| sel_count | output | 7 | Running, then final, population count |
| done | output | 1 | One-cycle pulse at the end of a scan |

## Verification
Every result has a fixed due time measured from the edge that accepts start. The write decision for element k is due k+1 clocks later, and the done pulse is due max(L,1) clocks later. The final count is due together with done and must not change in the cycle after it. The bench drives start on a falling edge and then samples once per clock, each time half a period after a rising edge. At each sample it compares the outputs with the single element that should have been decided at that edge, so an early, late or missing write or pulse shows up in the exact cycle it occurs. Random masks and lengths are mixed with directed cases: length 0, a length above 64, an all-zero mask, an all-ones mask, and a start injected in the middle of a scan.

// File: rtl/mask_compress.sv
module mask_compress #(
  parameter int ELEMS = 64,
  localparam int IDXW = $clog2(ELEMS),
  localparam int LENW = $clog2(ELEMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ELEMS-1:0] mask,
  input  logic [LENW-1:0]  vec_len,
  output logic             idx_wr_en,
  output logic [IDXW-1:0]  idx_slot,
  output logic [IDXW-1:0]  idx_value,
  output logic [LENW-1:0]  sel_count,
  output logic             done
);

  logic             busy;
  logic [ELEMS-1:0] mask_q;
  logic [LENW-1:0]  limit_q;
  logic [LENW-1:0]  pos_q;

  wire [LENW-1:0] len_clamped = (vec_len > LENW'(ELEMS)) ? LENW'(ELEMS) : vec_len;
  wire            last_pos    = (pos_q + LENW'(1)) == limit_q;
  wire            hit         = mask_q[pos_q[IDXW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      mask_q    <= '0;
      limit_q   <= '0;
      pos_q     <= '0;
      sel_count <= '0;
      idx_wr_en <= 1'b0;
      idx_slot  <= '0;
      idx_value <= '0;
      done      <= 1'b0;
    end else begin
      idx_wr_en <= 1'b0;
      done      <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          mask_q    <= mask;
          limit_q   <= len_clamped;
          pos_q     <= '0;
          sel_count <= '0;
        end
      end else if (limit_q == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        if (hit) begin
          idx_wr_en <= 1'b1;
          idx_slot  <= sel_count[IDXW-1:0];
          idx_value <= pos_q[IDXW-1:0];
          sel_count <= sel_count + LENW'(1);
        end
        pos_q <= pos_q + LENW'(1);
        if (last_pos) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mask_compress_chk.sv
module mask_compress_chk #(
  parameter int ELEMS = 64,
  localparam int IDXW = $clog2(ELEMS),
  localparam int LENW = $clog2(ELEMS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic [LENW-1:0] vec_len,
  input logic            idx_wr_en,
  input logic [IDXW-1:0] idx_slot,
  input logic [IDXW-1:0] idx_value,
  input logic [LENW-1:0] sel_count,
  input logic            done
);

  logic [LENW-1:0] lim_c;
  logic [IDXW-1:0] prev_idx;
  logic            have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_c     <= '0;
      prev_idx  <= '0;
      have_prev <= 1'b0;
    end else if (start && !busy) begin
      lim_c     <= (vec_len > LENW'(ELEMS)) ? LENW'(ELEMS) : vec_len;
      have_prev <= 1'b0;
    end else if (idx_wr_en) begin
      prev_idx  <= idx_value;
      have_prev <= 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_SLOT_DENSE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr_en |-> sel_count == LENW'(idx_slot) + LENW'(1)); // R1
  AST_INDEX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr_en && have_prev) |-> idx_value > prev_idx); // R1
  AST_INDEX_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr_en |-> LENW'(idx_value) < lim_c); // R2
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(sel_count)); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sel_count <= LENW'(ELEMS)); // R3

endmodule

bind mask_compress mask_compress_chk #(.ELEMS(ELEMS)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .vec_len(vec_len),
  .idx_wr_en(idx_wr_en), .idx_slot(idx_slot), .idx_value(idx_value),
  .sel_count(sel_count), .done(done)
);

// File: tb/mask_compress_tb_top.sv
`timescale 1ns/1ps
module mask_compress_tb_top;
  localparam int ELEMS = 64;
  localparam int IDXW  = 6;
  localparam int LENW  = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [ELEMS-1:0] mask = '0;
  logic [LENW-1:0]  vec_len = '0;
  logic             idx_wr_en;
  logic [IDXW-1:0]  idx_slot;
  logic [IDXW-1:0]  idx_value;
  logic [LENW-1:0]  sel_count;
  logic             done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  mask_compress #(.ELEMS(ELEMS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mask(mask), .vec_len(vec_len),
    .idx_wr_en(idx_wr_en), .idx_slot(idx_slot), .idx_value(idx_value),
    .sel_count(sel_count), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clamp_len(input int v);
    return (v > ELEMS) ? ELEMS : v;
  endfunction

  function automatic int ref_count(input logic [ELEMS-1:0] m, input int lim);
    int n = 0;
    for (int i = 0; i < lim; i++) if (m[i]) n++;
    return n;
  endfunction

  task automatic run_scan(input logic [ELEMS-1:0] m, input int v, input bit inject);
    int lim, steps, nwr, expc;
    lim   = clamp_len(v);
    steps = (lim == 0) ? 1 : lim;
    expc  = ref_count(m, lim);
    nwr   = 0;
    @(negedge clk);
    mask = m; vec_len = LENW'(v); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= steps; k++) begin
      if (inject && steps >= 3 && k == 2) begin
        start = 1'b1; mask = ~m; vec_len = LENW'(ELEMS);
      end
      if (inject && steps >= 3 && k == 3) start = 1'b0;
      @(negedge clk);
      if (lim > 0) begin
        chk(idx_wr_en == m[k-1], "R4 write decision (R2/R7)", idx_wr_en, m[k-1]);
        if (m[k-1] && idx_wr_en) begin
          chk(idx_slot == IDXW'(nwr), "R1 slot", idx_slot, nwr);
          chk(idx_value == IDXW'(k-1), "R1 index", idx_value, k-1);
          nwr++;
        end
      end else begin
        chk(!idx_wr_en, "R6 no write", idx_wr_en, 0);
      end
      chk(done == (k == steps), "R5 done timing", done, k == steps);
    end
    start = 1'b0;
    chk(sel_count == LENW'(expc), "R3 count (R6/R7)", sel_count, expc);
    @(negedge clk);
    chk(!done, "R5 single pulse", done, 0);
    chk(!idx_wr_en, "R2 no write past limit", idx_wr_en, 0);
    chk(sel_count == LENW'(expc), "R3 count held", sel_count, expc);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ELEMS-1:0] rm;
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    #1;
    chk(!idx_wr_en, "R8 reset wr_en", idx_wr_en, 0);
    chk(!done, "R8 reset done", done, 0);
    chk(sel_count == 0, "R8 reset count", sel_count, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(sel_count == 0, "R8 count after release", sel_count, 0);

    run_scan('0, 64, 1'b0);                               // R6 all zero
    run_scan({ELEMS{1'b1}}, 0, 1'b0);                     // R6 length zero
    run_scan({ELEMS{1'b1}}, 64, 1'b0);                    // R1 full
    run_scan({ELEMS{1'b1}}, 100, 1'b0);                   // R2 clamp
    run_scan(64'h8000_0000_0000_0001, 64, 1'b0);          // R5 last element
    run_scan(64'hFFFF_FFFF_FFFF_FF00, 8, 1'b0);           // R2 bits above length
    run_scan(64'h0000_0000_0000_00A5, 10, 1'b1);          // R7 mid-scan start
    run_scan(64'h1, 1, 1'b0);                             // R5 length one

    for (int t = 0; t < 40; t++) begin
      rm = {$urandom, $urandom};
      if (t % 3 == 0) rm = rm & {$urandom, $urandom} & {$urandom, $urandom};
      run_scan(rm, int'($urandom_range(0, 90)), (t % 5 == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule